// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver with ID Filtering

This block receives asynchronous serial frames that carry eight data bits and one extra address-marker bit. The line idles high. A frame is a low start bit, the data least significant bit first, the marker bit, and a high stop bit. The receiver samples the line on an external oversampling tick at sixteen ticks per bit. It decides each bit by a majority vote of three samples taken around the bit centre. Every completed frame is then either delivered to a holding register, flagged as an error, or dropped.

For shared multi-drop links the host can arm an ID-hunt mode. While this mode is armed, frames whose marker bit is 0 are dropped silently and no flag changes. The first frame whose marker bit is 1 is delivered, and the hardware then disarms the mode. Host software compares the delivered byte with its own station ID. On a mismatch it re-arms the mode. On a match it leaves the mode off, so the data frames that follow are delivered.

An overrun or framing error freezes reception until the host clears both error flags. The synchronized line level is always visible, so the host can detect a break.

Top module: `mpf_rx`

## Requirements
- R1: A frame with a high stop bit loads its eight data bits into `rx_data`. The first data bit on the line lands in bit 0. The frame also sets `rx_full` to 1.
- R2: `rx_mpb` takes the marker bit (the bit after D7) of every frame that is delivered.
- R3: While `id_mode` is 1, a frame whose marker bit is 0 leaves `rx_full`, `rx_data`, `rx_mpb` and `id_mode` unchanged.
- R4: While `id_mode` is 1, a frame whose marker bit is 1 is delivered and clears `id_mode` to 0. A pulse on `id_mode_set` sets `id_mode` to 1. With `id_mode` at 0, frames are delivered whatever their marker bit.
- R5: A good frame that completes while `rx_full` is 1 sets `rx_ovr`. `rx_data` keeps the older byte.
- R6: A frame whose stop bit votes 0 sets `rx_ferr`, does not change `rx_data` and does not set `rx_full`.
- R7: While `rx_ovr` or `rx_ferr` is 1, no frame is received. A pulse on `err_clr` clears both flags, and the next frame is received normally.
- R8: When a `full_clr` pulse falls in the same cycle as a frame completion, the clear is applied first. The new frame is then delivered and no overrun is flagged.
- R9: A low pulse on the idle line that is shorter than half a bit is rejected by the start-bit centre vote, and nothing is received.
- R10: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and at least one of `rx_full`, `rx_ovr` or `rx_ferr` is 1.
- R11: `rx_level` follows `rx_in` through a two-flop synchronizer. A sustained low (break) therefore appears there two cycles later.
- R12: After reset all flags, `id_mode` and `rx_data` are 0, and `rx_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| id_mode_set | input | 1 | Pulse: arm ID-hunt mode |
| rx_irq_en | input | 1 | Receive interrupt enable |
| full_clr | input | 1 | Pulse: clear receive-full flag |
| err_clr | input | 1 | Pulse: clear overrun and framing flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_ferr | output | 1 | Framing-error flag |
| rx_mpb | output | 1 | Marker bit of the last delivered frame |
| id_mode | output | 1 | ID-hunt mode armed |
| rx_irq | output | 1 | Receive interrupt request |
| rx_level | output | 1 | Synchronized line level |

## Verification
Two actions can fall in the same cycle: a host clear of the receive-full flag and the completion of the next frame. The clear must win over the overrun decision. The bench counts the cycles from the start edge it drives to the stop-bit vote, which is 171 cycles when the tick is held high. It then places the `full_clr` pulse exactly in that cycle. The result passes when the new byte sits in `rx_data` with `rx_full` at 1 and `rx_ovr` at 0. A second run places the clear one cycle late, and that run must flag an overrun.

// File: rtl/mpf_rx_pkg.sv
package mpf_rx_pkg;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/mpf_rx_sync.sv
module mpf_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mpf_rx_shifter.sv
module mpf_rx_shifter
    import mpf_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              hold,
    output logic              done,
    output logic              stop_ok,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_mpb
);
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int PHW        = $clog2(OSR);
    localparam int BIW        = $clog2(FRAME_BITS);
    localparam logic [PHW-1:0] PH_LAST = PHW'(OSR - 1);
    localparam logic [PHW-1:0] PH_VOTE = PHW'(OSR / 2 + 1);
    localparam logic [BIW-1:0] BI_STOP = BIW'(FRAME_BITS - 1);

    typedef struct packed {
        sh_state_e      state;
        logic [PHW-1:0] ph;
        logic [BIW-1:0] bidx;
        logic [2:0]     hist;
        logic [DATA_W:0] sh;
    } sh_regs_t;

    sh_regs_t q, d;
    logic [2:0]     hist_n;
    logic [PHW-1:0] ph_n;
    logic           vote;

    always_comb begin
        d       = q;
        done    = 1'b0;
        stop_ok = 1'b0;
        hist_n  = tick ? {q.hist[1:0], rx_s} : q.hist;
        vote    = maj3(hist_n);
        ph_n    = (q.ph == PH_LAST) ? '0 : q.ph + 1'b1;
        d.hist  = hist_n;
        case (q.state)
            SH_IDLE: begin
                if (tick && !hold && q.hist[0] && !rx_s) begin
                    d.state = SH_RUN;
                    d.ph    = '0;
                    d.bidx  = '0;
                end
            end
            default: begin
                if (hold) begin
                    d.state = SH_IDLE;
                end else if (tick) begin
                    d.ph = ph_n;
                    if (ph_n == '0) d.bidx = q.bidx + 1'b1;
                    if (ph_n == PH_VOTE) begin
                        if (q.bidx == '0) begin
                            if (vote) d.state = SH_IDLE;
                        end else if (q.bidx == BI_STOP) begin
                            done    = 1'b1;
                            stop_ok = vote;
                            d.state = SH_IDLE;
                        end else begin
                            d.sh = {vote, q.sh[DATA_W:1]};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= SH_IDLE;
            q.ph    <= '0;
            q.bidx  <= '0;
            q.hist  <= '1;
            q.sh    <= '0;
        end else begin
            q <= d;
        end
    end

    assign frm_data = q.sh[DATA_W-1:0];
    assign frm_mpb  = q.sh[DATA_W];
endmodule

// File: rtl/mpf_rx.sv
module mpf_rx
    import mpf_rx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OSR       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              id_mode_set,
    input  logic              rx_irq_en,
    input  logic              full_clr,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              rx_ferr,
    output logic              rx_mpb,
    output logic              id_mode,
    output logic              rx_irq,
    output logic              rx_level
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              full;
        logic              ovr;
        logic              fer;
        logic              mpie;
    } rx_regs_t;

    rx_regs_t q, d;
    logic              rx_s;
    logic              hold;
    logic              done;
    logic              stop_ok;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mpb;

    mpf_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    assign hold = q.ovr | q.fer;

    mpf_rx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx_s    (rx_s),
        .hold    (hold),
        .done    (done),
        .stop_ok (stop_ok),
        .frm_data(frm_data),
        .frm_mpb (frm_mpb)
    );

    always_comb begin
        d = q;
        if (full_clr)    d.full = 1'b0;
        if (err_clr)     begin d.ovr = 1'b0; d.fer = 1'b0; end
        if (id_mode_set) d.mpie = 1'b1;
        if (done) begin
            if (!stop_ok) begin
                d.fer = 1'b1;
            end else if (q.mpie && !frm_mpb) begin
                d.full = d.full;
            end else if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = frm_data;
                d.mpb  = frm_mpb;
                d.full = 1'b1;
                if (q.mpie) d.mpie = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data  = q.data;
    assign rx_full  = q.full;
    assign rx_ovr   = q.ovr;
    assign rx_ferr  = q.fer;
    assign rx_mpb   = q.mpb;
    assign id_mode  = q.mpie;
    assign rx_irq   = rx_irq_en & (q.full | q.ovr | q.fer);
    assign rx_level = rx_s;
endmodule

// File: rtl/mpf_rx_chk.sv
module mpf_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_irq_en,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rx_ovr,
    input logic              rx_ferr,
    input logic              rx_mpb,
    input logic              id_mode,
    input logic              rx_irq
);
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> !rx_irq);

    assert_irq_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && (rx_full || rx_ovr || rx_ferr)) |-> rx_irq);

    assert_ovr_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $stable(rx_data));

    assert_ferr_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ferr) |-> ($stable(rx_data) && !$rose(rx_full)));

    assert_id_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> (rx_full && rx_mpb));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr || rx_ferr) |=> ($stable(rx_data) && !$rose(rx_full)));
endmodule

bind mpf_rx mpf_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_irq_en(rx_irq_en),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .rx_ovr   (rx_ovr),
    .rx_ferr  (rx_ferr),
    .rx_mpb   (rx_mpb),
    .id_mode  (id_mode),
    .rx_irq   (rx_irq)
);

// File: tb/mpf_rx_tb.sv
`timescale 1ns/1ps
module mpf_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       id_mode_set = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic       full_clr = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_ovr, rx_ferr, rx_mpb, id_mode, rx_irq, rx_level;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    mpf_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .id_mode_set(id_mode_set), .rx_irq_en(rx_irq_en),
        .full_clr(full_clr), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .rx_ferr(rx_ferr), .rx_mpb(rx_mpb), .id_mode(id_mode),
        .rx_irq(rx_irq), .rx_level(rx_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic mpb, input logic stop);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        hold_bit(mpb);
        hold_bit(stop);
        hold_bit(1'b1);
    endtask

    task automatic pulse_full_clr();
        full_clr = 1'b1; @(negedge clk); full_clr = 1'b0;
    endtask

    task automatic pulse_err_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 data", 32'(rx_data), 32'h0);
        check("R12 flags", {28'h0, rx_full, rx_ovr, rx_ferr, id_mode}, 32'h0);
        check("R12 level", 32'(rx_level), 32'h1);
    endtask

    task automatic t_basic();
        rx_irq_en = 1'b1;
        send_frame(8'hA5, 1'b0, 1'b1);
        check("R1 data", 32'(rx_data), 32'hA5);
        check("R1 full", 32'(rx_full), 32'h1);
        check("R2 mpb0", 32'(rx_mpb), 32'h0);
        check("R10 irq on", 32'(rx_irq), 32'h1);
        rx_irq_en = 1'b0; @(negedge clk);
        check("R10 irq masked", 32'(rx_irq), 32'h0);
        rx_irq_en = 1'b1;
        pulse_full_clr();
        check("R10 irq off", 32'(rx_irq), 32'h0);
        send_frame(8'h3C, 1'b1, 1'b1);
        check("R2 mpb1", 32'(rx_mpb), 32'h1);
        check("R1 data2", 32'(rx_data), 32'h3C);
        pulse_full_clr();
    endtask

    task automatic t_filter();
        id_mode_set = 1'b1; @(negedge clk); id_mode_set = 1'b0;
        check("R4 armed", 32'(id_mode), 32'h1);
        send_frame(8'h11, 1'b0, 1'b1);
        check("R3 no full", 32'(rx_full), 32'h0);
        check("R3 data kept", 32'(rx_data), 32'h3C);
        check("R3 still armed", 32'(id_mode), 32'h1);
        send_frame(8'h42, 1'b1, 1'b1);
        check("R4 id data", 32'(rx_data), 32'h42);
        check("R4 id full", 32'(rx_full), 32'h1);
        check("R4 disarmed", 32'(id_mode), 32'h0);
        pulse_full_clr();
        send_frame(8'h55, 1'b0, 1'b1);
        check("R4 data after match", 32'(rx_data), 32'h55);
        check("R4 full after match", 32'(rx_full), 32'h1);
    endtask

    task automatic t_overrun();
        send_frame(8'h99, 1'b0, 1'b1);
        check("R5 ovr", 32'(rx_ovr), 32'h1);
        check("R5 data kept", 32'(rx_data), 32'h55);
        pulse_full_clr();
        check("R10 irq from ovr", 32'(rx_irq), 32'h1);
        send_frame(8'h77, 1'b0, 1'b1);
        check("R7 frozen full", 32'(rx_full), 32'h0);
        check("R7 frozen data", 32'(rx_data), 32'h55);
        pulse_err_clr();
        check("R7 cleared", 32'(rx_ovr), 32'h0);
        send_frame(8'h78, 1'b0, 1'b1);
        check("R7 resumed", 32'(rx_data), 32'h78);
        pulse_full_clr();
    endtask

    task automatic t_framing();
        send_frame(8'h12, 1'b0, 1'b0);
        check("R6 ferr", 32'(rx_ferr), 32'h1);
        check("R6 no full", 32'(rx_full), 32'h0);
        check("R6 data kept", 32'(rx_data), 32'h78);
        send_frame(8'h34, 1'b1, 1'b1);
        check("R7 frozen on ferr", 32'(rx_full), 32'h0);
        rx_in = 1'b0;
        @(negedge clk);
        check("R11 level lag", 32'(rx_level), 32'h1);
        @(negedge clk);
        check("R11 break seen", 32'(rx_level), 32'h0);
        repeat (40) @(negedge clk);
        check("R11 break held", 32'(rx_level), 32'h0);
        rx_in = 1'b1;
        repeat (20) @(negedge clk);
        pulse_err_clr();
        check("R7 ferr cleared", 32'(rx_ferr), 32'h0);
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (200) @(negedge clk);
        check("R9 glitch no full", 32'(rx_full), 32'h0);
        check("R9 glitch no ferr", 32'(rx_ferr), 32'h0);
        send_frame(8'hC3, 1'b0, 1'b1);
        check("R9 next frame ok", 32'(rx_data), 32'hC3);
    endtask

    task automatic t_coincide();
        check("R8 precondition", 32'(rx_full), 32'h1);
        fork
            send_frame(8'h6B, 1'b0, 1'b1);
            begin repeat (171) @(negedge clk); pulse_full_clr(); end
        join
        check("R8 full", 32'(rx_full), 32'h1);
        check("R8 no ovr", 32'(rx_ovr), 32'h0);
        check("R8 data", 32'(rx_data), 32'h6B);
        fork
            send_frame(8'h2D, 1'b0, 1'b1);
            begin repeat (172) @(negedge clk); pulse_full_clr(); end
        join
        check("R8 late clear ovr", 32'(rx_ovr), 32'h1);
        check("R8 late clear data", 32'(rx_data), 32'h6B);
        pulse_err_clr();
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_filter();
        t_overrun();
        t_framing();
        t_glitch();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule